// File: doc/BRIEF.md
# Wired Interrupt to Message-Write Bridge

This block gathers a large set of wired interrupt inputs and forwards each state change as a memory write toward a remote interrupt controller. There are no interrupt wires at the output. A set write tells the remote controller that an interrupt has become active. A clear write tells it that the interrupt has gone inactive. Software programs two 64-bit destination addresses, one for set writes and one for clear writes. It also programs one configuration word per input, which holds an enable, a sensing mode, a group code and a message number. The message number is the data payload of every write for that input.

Every input passes through a two-flop synchronizer before its changes are detected. A line that qualifies records a pending set or a pending clear. A round-robin arbiter picks one pending line at a time. The chosen write is placed on a request/acknowledge port and stays unchanged until it is acknowledged.

Top module: `icu_msg_bridge`

## Requirements
- R1: While reset is asserted and right after it is released, `msg_req` is low.
- R2: The register bus is write-only, with these byte addresses. Set destination: low word 0x10, high word 0x14. Clear destination: low word 0x18, high word 0x1C. Line i configuration: 0x100 + 4*i. In a configuration word, bits 6:0 are the message number (0 to 127), bit 24 is enable, bit 28 selects edge mode (0 selects level mode), and bits 31:29 are the group.
- R3: In level mode, a rising input produces one write of its message number to the set address. A falling input produces one write to the clear address. `msg_data` carries the message number in bits 6:0, and bits 31:7 are zero.
- R4: In edge mode, each rising input produces one set write. A falling input produces nothing.
- R5: Only groups 0 and 1 produce writes. A line whose group is any other value (for example 4 or 5) produces no write.
- R6: A line whose enable bit is clear produces no write. This includes writing zero to its configuration. A message that is pending on a line but not yet issued is dropped when that line is disabled.
- R7: While `msg_req` is high and `msg_ack` is low, `msg_req`, `msg_addr` and `msg_data` stay unchanged. In the cycle after an acknowledge, `msg_req` is low.
- R8: When several lines are pending, they are served in round-robin order by line index. The search starts at the line after the one served last. After reset, the search starts at line 0.
- R9: In level mode, if a line returns to its previous level before its pending message has been issued, the pending message is withdrawn and nothing is sent for that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (12) | Register byte address |
| reg_wdata | input | 32 | Register write data |
| irq_in | input | N_LINES (207) | Wired interrupt inputs, asynchronous |
| msg_req | output | 1 | Write request valid |
| msg_addr | output | 64 | Write destination address |
| msg_data | output | 32 | Write data, which is the message number |
| msg_ack | input | 1 | Write accepted by the fabric |

## Verification
The bench drives lines at both ends of the index range and message numbers 0 and 127. Address or field decoding that is off by one would then send writes to the wrong destination or with the wrong payload. It raises several lines in the same cycle and checks the order of service. An arbiter that always starts from line 0, or that does not advance, would serve them in the wrong order. Other tests hold a write unacknowledged while a second line pulses or is disabled. A design that failed to hold the request would change the write it has already issued. A design that failed to cancel or drop the pending message would send a stray set or clear write afterwards.

// File: rtl/icu_msg_pkg.sv
package icu_msg_pkg;
  localparam int MSG_W = 7;
  localparam logic [11:0] OFS_SET_LO = 12'h010;
  localparam logic [11:0] OFS_SET_HI = 12'h014;
  localparam logic [11:0] OFS_CLR_LO = 12'h018;
  localparam logic [11:0] OFS_CLR_HI = 12'h01C;
  localparam logic [11:0] OFS_CFG    = 12'h100;
  localparam int EN_BIT  = 24;
  localparam int EDG_BIT = 28;
  localparam int GRP_LSB = 29;

  typedef struct packed {
    logic             en;
    logic             edge_md;
    logic [2:0]       grp;
    logic [MSG_W-1:0] num;
  } line_cfg_t;

  function automatic logic grp_routed(input logic [2:0] g);
    return (g == 3'd0) || (g == 3'd1);
  endfunction
endpackage

// File: rtl/icu_cfg_regs.sv
module icu_cfg_regs
  import icu_msg_pkg::*;
#(
  parameter int N_LINES = 207,
  parameter int AW      = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [31:0]     wdata,
  output logic [63:0]     set_addr,
  output logic [63:0]     clr_addr,
  output line_cfg_t       cfg [N_LINES]
);
  logic we_set_lo, we_set_hi, we_clr_lo, we_clr_hi;
  line_cfg_t wcfg;
  logic unused_wbits;

  always_comb begin
    we_set_lo = we && (addr == AW'(OFS_SET_LO));
    we_set_hi = we && (addr == AW'(OFS_SET_HI));
    we_clr_lo = we && (addr == AW'(OFS_CLR_LO));
    we_clr_hi = we && (addr == AW'(OFS_CLR_HI));
    wcfg.en      = wdata[EN_BIT];
    wcfg.edge_md = wdata[EDG_BIT];
    wcfg.grp     = wdata[GRP_LSB +: 3];
    wcfg.num     = wdata[MSG_W-1:0];
  end
  assign unused_wbits = ^{wdata[EN_BIT-1:MSG_W], wdata[EDG_BIT-1:EN_BIT+1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_addr <= '0;
      clr_addr <= '0;
    end else begin
      if (we_set_lo) set_addr[31:0]  <= wdata;
      if (we_set_hi) set_addr[63:32] <= wdata;
      if (we_clr_lo) clr_addr[31:0]  <= wdata;
      if (we_clr_hi) clr_addr[63:32] <= wdata;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_cfg
    logic hit;
    assign hit = we && (addr == AW'(int'(OFS_CFG) + 4*i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg[i] <= '0;
      else if (hit) cfg[i] <= wcfg;
    end
  end
endmodule

// File: rtl/icu_line_evt.sv
module icu_line_evt
  import icu_msg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      irq,
  input  line_cfg_t cfg,
  input  logic      take_set,
  input  logic      take_clr,
  output logic      pend_set,
  output logic      pend_clr
);
  logic s1, s2, prev;
  logic rise, fall, active;
  logic ps_n, pc_n;
  logic unused_num;

  assign unused_num = ^cfg.num;
  assign rise   = s2 & ~prev;
  assign fall   = ~s2 & prev;
  assign active = cfg.en & grp_routed(cfg.grp);

  always_comb begin
    ps_n = pend_set & ~take_set;
    pc_n = pend_clr & ~take_clr;
    if (!active) begin
      ps_n = 1'b0;
      pc_n = 1'b0;
    end else if (cfg.edge_md) begin
      pc_n = 1'b0;
      if (rise) ps_n = 1'b1;
    end else begin
      if (rise) begin
        if (pc_n) pc_n = 1'b0;
        else      ps_n = 1'b1;
      end
      if (fall) begin
        if (ps_n) ps_n = 1'b0;
        else      pc_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; prev <= 1'b0;
      pend_set <= 1'b0; pend_clr <= 1'b0;
    end else begin
      s1 <= irq; s2 <= s1; prev <= s2;
      pend_set <= ps_n; pend_clr <= pc_n;
    end
  end
endmodule

// File: rtl/icu_rr_arb.sv
module icu_rr_arb #(
  parameter int N  = 207,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] gidx,
  output logic          gvalid
);
  logic [IW-1:0] ptr;

  always_comb begin
    gvalid = 1'b0;
    gidx   = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ptr) + 1 + i;
      if (idx >= N) idx = idx - N;
      if (!gvalid && req[idx]) begin
        gvalid = 1'b1;
        gidx   = IW'(idx);
      end
    end
    grant = gvalid ? (N'(1) << gidx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= IW'(N-1);
    else if (adv) ptr <= gidx;
  end
endmodule

// File: rtl/icu_msg_bridge.sv
module icu_msg_bridge
  import icu_msg_pkg::*;
#(
  parameter int N_LINES = 207,
  parameter int AW      = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [AW-1:0]      reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic [N_LINES-1:0] irq_in,
  output logic               msg_req,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic               msg_ack
);
  localparam int IW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [63:0]        set_addr, clr_addr;
  line_cfg_t          cfg [N_LINES];
  logic [N_LINES-1:0] pend_set, pend_clr, pend_any;
  logic [N_LINES-1:0] take_set, take_clr, grant;
  logic [IW-1:0]      gidx;
  logic               gvalid, issue, kind_set;
  logic               req_n;
  logic [63:0]        addr_n;
  logic [31:0]        data_n;

  icu_cfg_regs #(.N_LINES(N_LINES), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .set_addr(set_addr), .clr_addr(clr_addr), .cfg(cfg)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    icu_line_evt u_evt (
      .clk(clk), .rst_n(rst_n), .irq(irq_in[i]), .cfg(cfg[i]),
      .take_set(take_set[i]), .take_clr(take_clr[i]),
      .pend_set(pend_set[i]), .pend_clr(pend_clr[i])
    );
    assign pend_any[i] = pend_set[i] | pend_clr[i];
    assign take_set[i] = issue & grant[i] & pend_set[i];
    assign take_clr[i] = issue & grant[i] & ~pend_set[i];
  end

  icu_rr_arb #(.N(N_LINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(pend_any), .adv(issue),
    .grant(grant), .gidx(gidx), .gvalid(gvalid)
  );

  always_comb begin
    issue    = gvalid & ~msg_req;
    kind_set = pend_set[gidx];
    req_n    = msg_req;
    addr_n   = msg_addr;
    data_n   = msg_data;
    if (msg_req && msg_ack) req_n = 1'b0;
    if (issue) begin
      req_n  = 1'b1;
      addr_n = kind_set ? set_addr : clr_addr;
      data_n = {{(32-MSG_W){1'b0}}, cfg[gidx].num};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_req  <= 1'b0;
      msg_addr <= '0;
      msg_data <= '0;
    end else begin
      msg_req <= req_n;
      if (issue) begin
        msg_addr <= addr_n;
        msg_data <= data_n;
      end
    end
  end
endmodule

// File: rtl/icu_msg_bridge_chk.sv
module icu_msg_bridge_chk #(
  parameter int N = 207
) (
  input logic         clk,
  input logic         rst_n,
  input logic         msg_req,
  input logic         msg_ack,
  input logic [63:0]  msg_addr,
  input logic [31:0]  msg_data,
  input logic [N-1:0] grant,
  input logic         issue
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !msg_req);

  p_num_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> (msg_data[31:icu_msg_pkg::MSG_W] == '0));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && msg_ack) |=> !msg_req);

  p_issue_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !msg_req);

  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
endmodule

bind icu_msg_bridge icu_msg_bridge_chk #(.N(N_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_req(msg_req), .msg_ack(msg_ack),
  .msg_addr(msg_addr), .msg_data(msg_data), .grant(grant), .issue(issue)
);

// File: tb/icu_msg_bridge_tb.sv
module icu_msg_bridge_tb;
  localparam int N  = 207;
  localparam int AW = 12;
  localparam logic [63:0] SET_A = 64'h0000_0012_3456_7000;
  localparam logic [63:0] CLR_A = 64'h0000_0012_3456_7008;

  typedef struct packed {
    logic [7:0] line;
    logic       en;
    logic       edg;
    logic [2:0] grp;
    logic [6:0] num;
    logic       lvl;
    logic       exp;
    logic       is_set;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'd5,   1'b1, 1'b0, 3'd0, 7'd17,  1'b1, 1'b1, 1'b1},
    '{8'd5,   1'b1, 1'b0, 3'd0, 7'd17,  1'b0, 1'b1, 1'b0},
    '{8'd40,  1'b1, 1'b1, 3'd1, 7'd127, 1'b1, 1'b1, 1'b1},
    '{8'd40,  1'b1, 1'b1, 3'd1, 7'd127, 1'b0, 1'b0, 1'b0},
    '{8'd206, 1'b1, 1'b0, 3'd1, 7'd0,   1'b1, 1'b1, 1'b1},
    '{8'd206, 1'b1, 1'b0, 3'd1, 7'd0,   1'b0, 1'b1, 1'b0},
    '{8'd0,   1'b1, 1'b0, 3'd4, 7'd9,   1'b1, 1'b0, 1'b0},
    '{8'd0,   1'b1, 1'b0, 3'd4, 7'd9,   1'b0, 1'b0, 1'b0},
    '{8'd1,   1'b1, 1'b1, 3'd5, 7'd9,   1'b1, 1'b0, 1'b0},
    '{8'd2,   1'b0, 1'b0, 3'd0, 7'd9,   1'b1, 1'b0, 1'b0},
    '{8'd40,  1'b1, 1'b1, 3'd1, 7'd127, 1'b1, 1'b1, 1'b1},
    '{8'd100, 1'b1, 1'b0, 3'd0, 7'd64,  1'b1, 1'b1, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata;
  logic [N-1:0]  irq_in;
  logic          msg_req;
  logic [63:0]   msg_addr;
  logic [31:0]   msg_data;
  logic          msg_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  icu_msg_bridge #(.N_LINES(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .irq_in(irq_in), .msg_req(msg_req),
    .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic cfgw(input int line, input bit en, input bit edg,
                      input logic [2:0] grp, input logic [6:0] num);
    wr(AW'(12'h100 + 4*line), {grp, edg, 3'b000, en, 17'd0, num});
  endtask

  task automatic ack_it(input string tag);
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
    checks++;
    if (msg_req) begin
      errors++;
      $display("FAIL %s release: msg_req=%0b expected 0", tag, msg_req);
    end
  endtask

  task automatic expect_msg(input bit present, input logic [63:0] ea,
                            input logic [31:0] ed, input string tag);
    int n;
    n = 0;
    while (!msg_req && n < 40) begin
      @(negedge clk);
      n++;
    end
    checks++;
    if (present) begin
      if (!msg_req) begin
        errors++;
        $display("FAIL %s: msg_req=0 expected 1 (addr %h data %h)", tag, ea, ed);
      end else begin
        if (msg_addr !== ea || msg_data !== ed) begin
          errors++;
          $display("FAIL %s: addr=%h data=%h expected addr=%h data=%h",
                   tag, msg_addr, msg_data, ea, ed);
        end
        ack_it(tag);
      end
    end else if (msg_req) begin
      errors++;
      $display("FAIL %s: unexpected write addr=%h data=%h expected none",
               tag, msg_addr, msg_data);
      ack_it(tag);
    end
  endtask

  task automatic wait_req();
    int n;
    n = 0;
    while (!msg_req && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] ha;
    logic [31:0] hd;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    irq_in = '0; msg_ack = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (msg_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: msg_req=%0b expected 0", msg_req);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (msg_req !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: msg_req=%0b expected 0", msg_req);
    end

    // R2: destinations programmed word by word
    wr(AW'(12'h010), SET_A[31:0]);
    wr(AW'(12'h014), SET_A[63:32]);
    wr(AW'(12'h018), CLR_A[31:0]);
    wr(AW'(12'h01C), CLR_A[63:32]);

    // Vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      cfgw(int'(VEC[v].line), VEC[v].en, VEC[v].edg, VEC[v].grp, VEC[v].num);
      irq_in[VEC[v].line] = VEC[v].lvl;
      expect_msg(VEC[v].exp, VEC[v].is_set ? SET_A : CLR_A,
                 {25'd0, VEC[v].num}, $sformatf("R3/R4/R5/R6 vector %0d", v));
    end

    // R8: three lines at once; last served line is 100
    cfgw(3, 1'b1, 1'b0, 3'd0, 7'd3);
    cfgw(150, 1'b1, 1'b0, 3'd0, 7'd21);
    cfgw(120, 1'b1, 1'b0, 3'd0, 7'd22);
    irq_in[3] = 1'b1; irq_in[120] = 1'b1; irq_in[150] = 1'b1;
    expect_msg(1'b1, SET_A, 32'd22, "R8 first after 100");
    expect_msg(1'b1, SET_A, 32'd21, "R8 second");
    expect_msg(1'b1, SET_A, 32'd3,  "R8 wrap to low line");
    irq_in[3] = 1'b0; irq_in[120] = 1'b0; irq_in[150] = 1'b0;
    expect_msg(1'b1, CLR_A, 32'd22, "R8 clear order 1");
    expect_msg(1'b1, CLR_A, 32'd21, "R8 clear order 2");
    expect_msg(1'b1, CLR_A, 32'd3,  "R8 clear order 3");

    // R9: pulse on line 120 while another write is outstanding
    irq_in[3] = 1'b1;
    wait_req();
    ha = msg_addr; hd = msg_data;
    irq_in[120] = 1'b1;
    repeat (6) @(negedge clk);
    irq_in[120] = 1'b0;
    repeat (10) @(negedge clk);
    checks++;
    if (!msg_req || msg_addr !== ha || msg_data !== hd || hd !== 32'd3) begin
      errors++;
      $display("FAIL R7 hold: req=%0b addr=%h data=%h expected 1 %h %h",
               msg_req, msg_addr, msg_data, SET_A, 32'd3);
    end
    ack_it("R7 hold");
    expect_msg(1'b0, SET_A, 32'd22, "R9 withdrawn pulse");

    // R6: pending message dropped when its line is disabled
    irq_in[3] = 1'b0;
    wait_req();
    irq_in[150] = 1'b1;
    repeat (6) @(negedge clk);
    cfgw(150, 1'b0, 1'b0, 3'd0, 7'd0);
    checks++;
    if (!msg_req || msg_addr !== CLR_A || msg_data !== 32'd3) begin
      errors++;
      $display("FAIL R7 across cfg write: addr=%h data=%h expected %h %h",
               msg_addr, msg_data, CLR_A, 32'd3);
    end
    ack_it("R6 outstanding");
    expect_msg(1'b0, SET_A, 32'd21, "R6 dropped pending");
    irq_in[150] = 1'b0;
    expect_msg(1'b0, CLR_A, 32'd21, "R6 disabled fall");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule